// File: doc/BRIEF.md
# Packed Lane Arithmetic Unit

This block treats one 64-bit word as a row of smaller lanes and runs a single operation across all of them at once. Addition and subtraction work on 8-, 16- or 32-bit lanes. One full-width adder does the work. The top bit of every lane is held out of the carry chain and then restored with an XOR, so no carry or borrow crosses from one lane into the next.

For bytes, the unit also reports which bytes of operand a are zero, or which are non-zero. The answer is built with a carry trick and lands as a boolean in bit 0 of each byte. In 32-bit lanes the unit shifts both halves of operand a left, logically right or arithmetically right. Both halves use the same shift amount, taken from operand b.

The result is registered, so it appears one clock after the inputs are presented. Reset is synchronous and active-high. Any combination of operation and lane size that is not defined returns zero.

Top module: `swar_lane_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `res_o` becomes zero. Otherwise `res_o` takes, at each rising edge, the result of the inputs present at that edge.
- R2: Operation code 0 (add) with lane select 0, 1 or 2 (8, 16 or 32-bit lanes) gives each lane of `res_o` the sum of the same lanes of `a_i` and `b_i`, modulo 2 to the lane width. No carry passes between lanes.
- R3: Operation code 1 (subtract) with lane select 0, 1 or 2 gives each lane the lane of `a_i` minus the lane of `b_i`, modulo 2 to the lane width. No borrow passes between lanes.
- R4: Operation code 2 (byte zero test) with lane select 0 sets bit 0 of each result byte to 1 exactly when that byte of `a_i` is 0x00. Bits 7..1 of every byte stay zero.
- R5: Operation code 3 (byte non-zero test) with lane select 0 sets bit 0 of each result byte to 1 exactly when that byte of `a_i` is not 0x00. Bits 7..1 of every byte stay zero.
- R6: Operation code 4 (shift left) with lane select 2 shifts each 32-bit half of `a_i` left by `b_i[4:0]` and fills with zeros. Bits 63..5 of `b_i` have no effect.
- R7: Operation code 5 (logical shift right) with lane select 2 shifts each 32-bit half of `a_i` right by `b_i[4:0]` and fills with zeros.
- R8: Operation code 6 (arithmetic shift right) with lane select 2 shifts each 32-bit half of `a_i` right by `b_i[4:0]` and fills with that half's bit 31.
- R9: The result is zero for all of the following: operation code 7, lane select 3, codes 2 or 3 with a lane select other than 0, and codes 4, 5 or 6 with a lane select other than 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code (0 add, 1 sub, 2 byte zero, 3 byte non-zero, 4 shl, 5 shr logical, 6 shr arithmetic, 7 reserved) |
| lsel_i | input | 2 | Lane size (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = none) |
| a_i | input | 64 | Operand a |
| b_i | input | 64 | Operand b |
| res_o | output | 64 | Registered lane-wise result |

## Verification
Some properties are checked by assertions on every cycle:
- the reset value;
- adding a zero operand returns a unchanged, in every lane size;
- a minus a gives zero;
- byte results never set bits 7..1;
- the zero-test and non-zero-test masks are bitwise complements in bit 0 of every byte;
- every undefined combination yields zero.

Exact lane values can only be shown by the bench sweep. It compares each lane against a per-lane reference loop over all operation codes and lane sizes. The operands include values that stress carry and borrow at lane edges, words with scattered zero bytes, and shift operands with noise in the upper bits of b.

// File: rtl/swar_pkg.sv
package swar_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_EQZ  = 3'd2,
    OP_NEZ  = 3'd3,
    OP_SHL  = 3'd4,
    OP_SHRU = 3'd5,
    OP_SHRS = 3'd6,
    OP_RSVD = 3'd7
  } swar_op_e;

  typedef enum logic [1:0] {
    LS_8    = 2'd0,
    LS_16   = 2'd1,
    LS_32   = 2'd2,
    LS_NONE = 2'd3
  } swar_lsel_e;

  localparam int unsigned NUM_LSIZES = 3;
  localparam int unsigned BASE_LANE_W = 8;
endpackage

// File: rtl/swar_addsub.sv
module swar_addsub #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned LANE_W = 8
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] sum_o,
  output logic [WORD_W-1:0] diff_o
);
  // Mask holding the top bit of every lane.
  logic [WORD_W-1:0] top_m;

  for (genvar i = 0; i < WORD_W; i++) begin : g_mask
    assign top_m[i] = ((i % LANE_W) == (LANE_W - 1));
  end

  // Lane tops are kept out of the shared carry chain and restored by XOR.
  assign sum_o  = ((a_i & ~top_m) + (b_i & ~top_m)) ^ ((a_i ^ b_i) & top_m);
  assign diff_o = ((a_i | top_m) - (b_i & ~top_m)) ^ (~(a_i ^ b_i) & top_m);
endmodule

// File: rtl/swar_zero_test.sv
module swar_zero_test #(
  parameter int unsigned WORD_W = 64
) (
  input  logic [WORD_W-1:0] v_i,
  output logic [WORD_W-1:0] eq_o,
  output logic [WORD_W-1:0] ne_o
);
  localparam int unsigned NBYTES = WORD_W / 8;
  localparam logic [WORD_W-1:0] LOW7 = {NBYTES{8'h7f}};

  logic [WORD_W-1:0] carry_t;
  logic [WORD_W-1:0] eq_top;
  logic [WORD_W-1:0] ne_top;

  // Adding 0x7f to the low seven bits carries into bit 7 when any of them is set.
  assign carry_t = (v_i & LOW7) + LOW7;
  assign eq_top  = ~(carry_t | LOW7 | v_i);
  assign ne_top  = (carry_t | v_i) & ~LOW7;

  // Move each byte's bit 7 down to bit 0 of the same byte.
  assign eq_o = eq_top >> 7;
  assign ne_o = ne_top >> 7;
endmodule

// File: rtl/swar_shift32.sv
module swar_shift32 #(
  parameter int unsigned WORD_W = 64
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] shl_o,
  output logic [WORD_W-1:0] shru_o,
  output logic [WORD_W-1:0] shrs_o
);
  localparam int unsigned HALF_W = 32;
  localparam int unsigned NHALF  = WORD_W / HALF_W;
  localparam int unsigned AMT_W  = $clog2(HALF_W);

  logic [AMT_W-1:0] amt;
  assign amt = b_i[AMT_W-1:0];

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic signed [HALF_W-1:0] part;
    assign part = a_i[h*HALF_W +: HALF_W];
    assign shl_o[h*HALF_W +: HALF_W]  = part << amt;
    assign shru_o[h*HALF_W +: HALF_W] = part >> amt;
    assign shrs_o[h*HALF_W +: HALF_W] = part >>> amt;
  end
endmodule

// File: rtl/swar_lane_unit.sv
module swar_lane_unit #(
  parameter int unsigned WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_i,
  input  logic [1:0]        lsel_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] res_o
);
  import swar_pkg::*;

  localparam int unsigned NBYTES = WORD_W / 8;
  localparam logic [WORD_W-1:0] BIT0_M = {NBYTES{8'h01}};

  logic [WORD_W-1:0] sum_l  [NUM_LSIZES];
  logic [WORD_W-1:0] diff_l [NUM_LSIZES];
  logic [WORD_W-1:0] eq_w, ne_w, shl_w, shru_w, shrs_w;
  logic [WORD_W-1:0] nxt;
  swar_op_e   op;
  swar_lsel_e ls;

  assign op = swar_op_e'(op_i);
  assign ls = swar_lsel_e'(lsel_i);

  for (genvar g = 0; g < NUM_LSIZES; g++) begin : g_lane
    swar_addsub #(.WORD_W(WORD_W), .LANE_W(BASE_LANE_W << g)) u_addsub (
      .a_i(a_i), .b_i(b_i), .sum_o(sum_l[g]), .diff_o(diff_l[g])
    );
  end

  swar_zero_test #(.WORD_W(WORD_W)) u_zero (
    .v_i(a_i), .eq_o(eq_w), .ne_o(ne_w)
  );

  swar_shift32 #(.WORD_W(WORD_W)) u_shift (
    .a_i(a_i), .b_i(b_i), .shl_o(shl_w), .shru_o(shru_w), .shrs_o(shrs_w)
  );

  always_comb begin
    nxt = '0;
    case (op)
      OP_ADD:  if (ls != LS_NONE) nxt = sum_l[lsel_i];
      OP_SUB:  if (ls != LS_NONE) nxt = diff_l[lsel_i];
      OP_EQZ:  if (ls == LS_8)    nxt = eq_w;
      OP_NEZ:  if (ls == LS_8)    nxt = ne_w;
      OP_SHL:  if (ls == LS_32)   nxt = shl_w;
      OP_SHRU: if (ls == LS_32)   nxt = shru_w;
      OP_SHRS: if (ls == LS_32)   nxt = shrs_w;
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) res_o <= '0;
    else     res_o <= nxt;
  end

  // R1: reset clears the output.
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> res_o == '0);

  // R2: adding a zero operand leaves a unchanged.
  a_r2_add_zero_identity: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd0 && lsel_i != 2'd3 && b_i == '0) |=> res_o == $past(a_i));

  // R3: a minus a is zero.
  a_r3_sub_self_zero: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd1 && lsel_i != 2'd3 && a_i == b_i) |=> res_o == '0);

  // R4 and R5: byte booleans only in bit 0.
  a_r4_byte_bool_low_only: assert property (@(posedge clk) disable iff (rst)
    ((op_i == 3'd2 || op_i == 3'd3) && lsel_i == 2'd0) |=> (res_o & ~BIT0_M) == '0);

  // R5: the zero and non-zero masks complement each other.
  a_r5_eq_ne_complement: assert property (@(posedge clk) disable iff (rst)
    (eq_w ^ ne_w) == BIT0_M);

  // R9: undefined combinations return zero.
  a_r9_undefined_zero: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd7 || lsel_i == 2'd3 ||
     ((op_i == 3'd2 || op_i == 3'd3) && lsel_i != 2'd0) ||
     ((op_i == 3'd4 || op_i == 3'd5 || op_i == 3'd6) && lsel_i != 2'd2))
    |=> res_o == '0);
endmodule

// File: tb/swar_lane_unit_tb.sv
module swar_lane_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_i = '0;
  logic [1:0]  lsel_i = '0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic [63:0] res_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [63:0] rng = 64'h9e3779b97f4a7c15;

  always #2.5 clk = ~clk;

  swar_lane_unit dut_i (
    .clk(clk), .rst(rst), .op_i(op_i), .lsel_i(lsel_i),
    .a_i(a_i), .b_i(b_i), .res_o(res_o)
  );

  function automatic logic [63:0] next_rand(input logic [63:0] s);
    logic [63:0] x = s;
    x ^= x << 13;
    x ^= x >> 7;
    x ^= x << 17;
    return x;
  endfunction

  function automatic string tag_of(input int op, input int ls);
    if (op == 7 || ls == 3) return "R9";
    case (op)
      0: return "R2";
      1: return "R3";
      2: return (ls == 0) ? "R4" : "R9";
      3: return (ls == 0) ? "R5" : "R9";
      4: return (ls == 2) ? "R6" : "R9";
      5: return (ls == 2) ? "R7" : "R9";
      default: return (ls == 2) ? "R8" : "R9";
    endcase
  endfunction

  function automatic logic [63:0] ref_of(input int op, input int ls,
                                         input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r = '0;
    int lw;
    logic [63:0] m;
    logic [63:0] la, lb;
    logic [31:0] ha;
    logic signed [31:0] hs;
    int amt;
    if (ls == 3) return '0;
    lw = 8 << ls;
    m = (64'h1 << lw) - 64'h1;
    amt = int'(b[4:0]);
    case (op)
      0, 1: begin
        for (int i = 0; i < 64 / lw; i++) begin
          la = (a >> (i * lw)) & m;
          lb = (b >> (i * lw)) & m;
          r |= (((op == 0) ? (la + lb) : (la - lb)) & m) << (i * lw);
        end
      end
      2, 3: begin
        if (ls == 0)
          for (int i = 0; i < 8; i++)
            r[i*8] = (op == 2) ? (a[i*8 +: 8] == 8'h00) : (a[i*8 +: 8] != 8'h00);
      end
      4, 5, 6: begin
        if (ls == 2)
          for (int h = 0; h < 2; h++) begin
            ha = a[h*32 +: 32];
            hs = ha;
            if (op == 4)      r[h*32 +: 32] = ha << amt;
            else if (op == 5) r[h*32 +: 32] = ha >> amt;
            else              r[h*32 +: 32] = hs >>> amt;
          end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] pattern(input int k, input logic [63:0] r1, input logic [63:0] r2);
    logic [63:0] v = r1;
    case (k % 8)
      0: v = 64'h0;
      1: v = 64'hffff_ffff_ffff_ffff;
      2: v = 64'h8080_8080_8080_8080;
      3: v = 64'h7f7f_7fff_7fff_ffff;
      4: v = 64'h8000_0001_0000_8000;
      5: for (int i = 0; i < 8; i++) if (r2[i*8]) v[i*8 +: 8] = 8'h00;
      6: v = {r1[63:32] | 32'h8000_0000, r1[31:0]};
      default: v = r1;
    endcase
    return v;
  endfunction

  initial begin
    #(5.0 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [63:0] r1, r2, a, b;
    // R1: reset holds the output at zero.
    op_i = 3'd0; lsel_i = 2'd0; a_i = 64'h1234_5678_9abc_def0; b_i = 64'h1111_1111_1111_1111;
    repeat (3) @(negedge clk);
    check("R1", res_o, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", res_o, ref_of(0, 0, a_i, b_i));

    for (int op = 0; op < 8; op++) begin
      for (int ls = 0; ls < 4; ls++) begin
        for (int k = 0; k < 48; k++) begin
          rng = next_rand(rng); r1 = rng;
          rng = next_rand(rng); r2 = rng;
          a = pattern(k, r1, r2);
          rng = next_rand(rng);
          b = pattern(k / 8 + k * 3, rng, r1);
          @(negedge clk);
          op_i = op[2:0]; lsel_i = ls[1:0]; a_i = a; b_i = b;
          @(negedge clk);
          check(tag_of(op, ls), res_o, ref_of(op, ls, a, b));
        end
      end
    end

    // R6: high bits of b do not change a shift.
    @(negedge clk);
    op_i = 3'd4; lsel_i = 2'd2; a_i = 64'h0000_0001_8000_0001; b_i = 64'hffff_ffff_ffff_ffe3;
    @(negedge clk);
    check("R6", res_o, 64'h0000_0008_0000_0008);
    // R8: arithmetic shift fills with each half's sign.
    op_i = 3'd6; lsel_i = 2'd2; a_i = 64'h8000_0000_4000_0000; b_i = 64'h0000_0000_0000_001f;
    @(negedge clk);
    check("R8", res_o, 64'hffff_ffff_0000_0000);
    // R2: carries do not cross byte lanes.
    op_i = 3'd0; lsel_i = 2'd0; a_i = 64'hffff_ffff_ffff_ffff; b_i = 64'h0101_0101_0101_0101;
    @(negedge clk);
    check("R2", res_o, 64'h0);
    // R3: borrows do not cross halfword lanes.
    op_i = 3'd1; lsel_i = 2'd1; a_i = 64'h0; b_i = 64'h0001_0001_0001_0001;
    @(negedge clk);
    check("R3", res_o, 64'hffff_ffff_ffff_ffff);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule